// File: doc/BRIEF.md
# Virtual Interrupt List-Register Arbiter

This block is the virtual half of a processor's interrupt interface. A hypervisor fills a small array of list registers. Each 32-bit entry describes one virtual interrupt by its identifier, priority, group and state. Every cycle the block scans the array and picks the pending entry with the numerically lowest priority. It then decides whether that entry becomes the guest's current-pending interrupt and whether it raises the virtual IRQ line or the virtual FIQ line.

Signalling depends on the hypervisor control register enable and on the guest-side controls. These controls are the two group enables, the FIQ routing enable, the priority mask and the running priority. The hypervisor control register also holds a 5-bit end-of-interrupt counter. It counts each deactivation pulse that found no matching list entry.

The outputs are combinational from the registered list entries, the registered control register and the guest-side control inputs. A register write therefore shows at the outputs in the cycle that follows its clock edge.

Top module: `virt_irq_arbiter`

## Requirements
- R1: After reset every list entry is zero (invalid), the control register reads zero, both virtual lines are low and the current-pending ID is 1023.
- R2: Only entries whose state field (bits [29:28]) holds 01 (pending) take part in selection. The other codes are 00 invalid, 10 active and 11 active-plus-pending, and entries with those codes are skipped.
- R3: Priority is bits [27:23], compared as the 8-bit value {prio,3'b000}. The lowest value wins, and equal values go to the lowest list index. With no pending entry the current-pending ID is 1023 and both lines are low.
- R4: When control-register bit 0 is clear, or when both guest group enables are clear, both lines are low and the current-pending ID is 1023.
- R5: When signalling is enabled, the winner's ID (bits [9:0]) is the current-pending ID only if its 8-bit priority is strictly below the priority mask. Otherwise the ID reads 1023.
- R6: A line is raised only if the winner is below the mask, is strictly below the running priority, and has its group (bit 30: 0 or 1) enabled by the matching guest group enable.
- R7: A signalled group-0 winner drives the FIQ line when the FIQ enable is set. Every other signalled winner drives the IRQ line. The two lines are never high together.
- R8: Each deactivation-miss pulse adds one, modulo 32, to control-register bits [31:27]. In a cycle that also writes the control register, the increment applies to the written value.
- R9: A list-register write or control-register write takes effect at its clock edge, and the outputs reflect it from that edge onward.
- R10: The hardware flag (bit 31) and bits [22:10] of an entry have no effect on selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_wr_en | input | 1 | List-register write strobe |
| lr_wr_sel | input | IDXW | Index of the list register to write |
| lr_wr_data | input | 32 | List-register write data |
| hcr_wr_en | input | 1 | Control-register write strobe |
| hcr_wr_data | input | 32 | Control-register write data |
| deact_miss | input | 1 | Deactivation with no matching entry (one pulse per event) |
| vgrp0_en | input | 1 | Guest group-0 enable |
| vgrp1_en | input | 1 | Guest group-1 enable |
| vfiq_en | input | 1 | Route signalled group-0 winners to FIQ |
| vprio_mask | input | 8 | Guest priority mask |
| vrun_prio | input | 8 | Guest running priority |
| virq | output | 1 | Virtual IRQ line |
| vfiq | output | 1 | Virtual FIQ line |
| vcur_pend_id | output | 10 | Current-pending virtual ID, 1023 when none |
| hcr_rd | output | 32 | Control-register contents |

## Verification
A wrong list entry or a misread field changes the winner. That shows as a wrong current-pending ID, or as the wrong line, in the cycle right after the write, because nothing sits between the stored entries and the outputs. A miscounted end-of-interrupt field shows on the control-register readback one cycle after the pulse. The bench's per-cycle model catches the error there, in directed tie, mask, group and wrap cases and over a long random stream of writes and control changes.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    localparam int VID_W     = 10;
    localparam int PRIO_W    = 5;
    localparam int PRIO_CMP_W = 8;
    localparam int EOI_W     = 5;
    localparam logic [VID_W-1:0] NO_VID = 10'd1023;

    typedef enum logic [1:0] {
        LR_INVALID  = 2'b00,
        LR_PENDING  = 2'b01,
        LR_ACTIVE   = 2'b10,
        LR_ACT_PEND = 2'b11
    } lr_state_e;

    typedef struct packed {
        logic              hw;
        logic              grp;
        lr_state_e         state;
        logic [PRIO_W-1:0] prio;
        logic [12:0]       rsvd;
        logic [VID_W-1:0]  vid;
    } lr_entry_t;

    typedef struct packed {
        logic [EOI_W-1:0] eoi_cnt;
        logic [25:0]      rsvd;
        logic             en;
    } hcr_t;

    function automatic logic [PRIO_CMP_W:0] widen_prio(input logic [PRIO_W-1:0] p);
        return {1'b0, p, 3'b000};
    endfunction

endpackage

// File: rtl/vlr_regfile.sv
module vlr_regfile
    import vlr_pkg::*;
#(
    parameter int N_LR = 4,
    localparam int IDXW = (N_LR > 1) ? $clog2(N_LR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lr_wr_en,
    input  logic [IDXW-1:0]        lr_wr_sel,
    input  logic [31:0]            lr_wr_data,
    input  logic                   hcr_wr_en,
    input  logic [31:0]            hcr_wr_data,
    input  logic                   deact_miss,
    output lr_entry_t [N_LR-1:0]   lr_q,
    output hcr_t                   hcr_q
);

    typedef struct packed {
        lr_entry_t [N_LR-1:0] lr;
        hcr_t                 hcr;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lr_wr_en && (int'(lr_wr_sel) < N_LR)) begin
            st_d.lr[lr_wr_sel] = lr_entry_t'(lr_wr_data);
        end
        if (hcr_wr_en) begin
            st_d.hcr = hcr_t'(hcr_wr_data);
        end
        if (deact_miss) begin
            st_d.hcr.eoi_cnt = st_d.hcr.eoi_cnt + 5'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lr_q  = st_q.lr;
    assign hcr_q = st_q.hcr;

    a_r8_eoi_step: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_miss && !hcr_wr_en) |=> (hcr_q.eoi_cnt == $past(hcr_q.eoi_cnt) + 5'd1));

    a_r8_eoi_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_miss && hcr_wr_en) |=> (hcr_q.eoi_cnt == $past(hcr_wr_data[31:27]) + 5'd1));

    a_r9_hcr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!deact_miss && !hcr_wr_en) |=> $stable(hcr_q));

    a_r9_lr_write: assert property (@(posedge clk) disable iff (!rst_n)
        lr_wr_en |=> (32'(lr_q[$past(lr_wr_sel)]) == $past(lr_wr_data)));

endmodule

// File: rtl/vlr_select.sv
module vlr_select
    import vlr_pkg::*;
#(
    parameter int N_LR = 4,
    localparam int IDXW = (N_LR > 1) ? $clog2(N_LR) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  lr_entry_t [N_LR-1:0]    lr,
    output logic                    best_found,
    output logic [IDXW-1:0]         best_idx,
    output logic [VID_W-1:0]        best_vid,
    output logic [PRIO_CMP_W:0]     best_prio,
    output logic                    best_grp
);

    always_comb begin
        best_found = 1'b0;
        best_idx   = '0;
        best_vid   = NO_VID;
        best_prio  = 9'h100;
        best_grp   = 1'b0;
        for (int i = 0; i < N_LR; i++) begin
            if (lr[i].state == LR_PENDING && widen_prio(lr[i].prio) < best_prio) begin
                best_found = 1'b1;
                best_idx   = IDXW'(i);
                best_vid   = lr[i].vid;
                best_prio  = widen_prio(lr[i].prio);
                best_grp   = lr[i].grp;
            end
        end
    end

    a_r2_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        best_found |-> (lr[best_idx].state == LR_PENDING));

    a_r3_empty_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        !best_found |-> (best_vid == NO_VID && best_prio == 9'h100));

    for (genvar g = 0; g < N_LR; g++) begin : g_chk
        a_r3_none_better: assert property (@(posedge clk) disable iff (!rst_n)
            (lr[g].state == LR_PENDING) |->
                (best_found && best_prio <= widen_prio(lr[g].prio)));
        a_r3_tie_low_index: assert property (@(posedge clk) disable iff (!rst_n)
            (lr[g].state == LR_PENDING && best_found && IDXW'(g) < best_idx) |->
                (widen_prio(lr[g].prio) > best_prio));
    end

endmodule

// File: rtl/vlr_signal.sv
module vlr_signal
    import vlr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                best_found,
    input  logic [VID_W-1:0]    best_vid,
    input  logic [PRIO_CMP_W:0] best_prio,
    input  logic                best_grp,
    input  logic                iface_en,
    input  logic                grp0_en,
    input  logic                grp1_en,
    input  logic                fiq_route,
    input  logic [7:0]          prio_mask,
    input  logic [7:0]          run_prio,
    output logic                irq_o,
    output logic                fiq_o,
    output logic [VID_W-1:0]    cur_vid
);

    logic sig_on_d, below_mask_d, below_run_d, grp_ok_d, fire_d;

    always_comb begin
        sig_on_d     = iface_en && (grp0_en || grp1_en);
        below_mask_d = best_prio < {1'b0, prio_mask};
        below_run_d  = best_prio < {1'b0, run_prio};
        grp_ok_d     = best_grp ? grp1_en : grp0_en;
        fire_d       = sig_on_d && best_found && below_mask_d && below_run_d && grp_ok_d;
        cur_vid      = (sig_on_d && best_found && below_mask_d) ? best_vid : NO_VID;
        fiq_o        = fire_d && !best_grp && fiq_route;
        irq_o        = fire_d && !(!best_grp && fiq_route);
    end

    a_r7_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && fiq_o));

    a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!iface_en || (!grp0_en && !grp1_en)) |-> (!irq_o && !fiq_o && cur_vid == NO_VID));

    a_r6_below_running: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (best_prio < {1'b0, run_prio} && cur_vid == best_vid));

    a_r7_fiq_group0: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (!best_grp && fiq_route && grp0_en));

endmodule

// File: rtl/virt_irq_arbiter.sv
module virt_irq_arbiter
    import vlr_pkg::*;
#(
    parameter int N_LR = 4,
    localparam int IDXW = (N_LR > 1) ? $clog2(N_LR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lr_wr_en,
    input  logic [IDXW-1:0] lr_wr_sel,
    input  logic [31:0]     lr_wr_data,
    input  logic            hcr_wr_en,
    input  logic [31:0]     hcr_wr_data,
    input  logic            deact_miss,
    input  logic            vgrp0_en,
    input  logic            vgrp1_en,
    input  logic            vfiq_en,
    input  logic [7:0]      vprio_mask,
    input  logic [7:0]      vrun_prio,
    output logic            virq,
    output logic            vfiq,
    output logic [9:0]      vcur_pend_id,
    output logic [31:0]     hcr_rd
);

    lr_entry_t [N_LR-1:0] lr_q;
    hcr_t                 hcr_q;
    logic                 best_found;
    logic [IDXW-1:0]      best_idx;
    logic [VID_W-1:0]     best_vid;
    logic [PRIO_CMP_W:0]  best_prio;
    logic                 best_grp;

    vlr_regfile #(.N_LR(N_LR)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .lr_wr_en    (lr_wr_en),
        .lr_wr_sel   (lr_wr_sel),
        .lr_wr_data  (lr_wr_data),
        .hcr_wr_en   (hcr_wr_en),
        .hcr_wr_data (hcr_wr_data),
        .deact_miss  (deact_miss),
        .lr_q        (lr_q),
        .hcr_q       (hcr_q)
    );

    vlr_select #(.N_LR(N_LR)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr         (lr_q),
        .best_found (best_found),
        .best_idx   (best_idx),
        .best_vid   (best_vid),
        .best_prio  (best_prio),
        .best_grp   (best_grp)
    );

    vlr_signal u_sig (
        .clk        (clk),
        .rst_n      (rst_n),
        .best_found (best_found),
        .best_vid   (best_vid),
        .best_prio  (best_prio),
        .best_grp   (best_grp),
        .iface_en   (hcr_q.en),
        .grp0_en    (vgrp0_en),
        .grp1_en    (vgrp1_en),
        .fiq_route  (vfiq_en),
        .prio_mask  (vprio_mask),
        .run_prio   (vrun_prio),
        .irq_o      (virq),
        .fiq_o      (vfiq),
        .cur_vid    (vcur_pend_id)
    );

    assign hcr_rd = 32'(hcr_q);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (hcr_rd == 32'd0 && !virq && !vfiq && vcur_pend_id == NO_VID));

endmodule

// File: tb/virt_irq_arbiter_bench.sv
`timescale 1ns/1ps
module virt_irq_arbiter_bench;

    localparam int N_LR = 4;
    localparam int IDXW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lr_wr_en = 1'b0;
    logic [IDXW-1:0] lr_wr_sel = '0;
    logic [31:0]     lr_wr_data = '0;
    logic            hcr_wr_en = 1'b0;
    logic [31:0]     hcr_wr_data = '0;
    logic            deact_miss = 1'b0;
    logic            vgrp0_en = 1'b0;
    logic            vgrp1_en = 1'b0;
    logic            vfiq_en = 1'b0;
    logic [7:0]      vprio_mask = '0;
    logic [7:0]      vrun_prio = '0;
    logic            virq, vfiq;
    logic [9:0]      vcur_pend_id;
    logic [31:0]     hcr_rd;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] m_lr [N_LR];
    logic [31:0] m_hcr;

    always #4 clk = ~clk;

    virt_irq_arbiter #(.N_LR(N_LR)) u_virt_irq_arbiter (
        .clk(clk), .rst_n(rst_n),
        .lr_wr_en(lr_wr_en), .lr_wr_sel(lr_wr_sel), .lr_wr_data(lr_wr_data),
        .hcr_wr_en(hcr_wr_en), .hcr_wr_data(hcr_wr_data), .deact_miss(deact_miss),
        .vgrp0_en(vgrp0_en), .vgrp1_en(vgrp1_en), .vfiq_en(vfiq_en),
        .vprio_mask(vprio_mask), .vrun_prio(vrun_prio),
        .virq(virq), .vfiq(vfiq), .vcur_pend_id(vcur_pend_id), .hcr_rd(hcr_rd)
    );

    function automatic logic [31:0] mk(input int vid, input int prio, input int state,
                                       input int grp, input int hw);
        return (32'(hw) << 31) | (32'(grp) << 30) | (32'(state) << 28)
             | (32'(prio) << 23) | 32'(vid);
    endfunction

    task automatic compare(input string tag);
        int best, bid, bg, st, p;
        bit en, fire, efiq, eirq;
        int ecur;
        best = 256; bid = 1023; bg = 0;
        foreach (m_lr[i]) begin
            st = int'((m_lr[i] >> 28) & 3);
            p  = int'((m_lr[i] >> 23) & 31) * 8;
            if (st == 1 && p < best) begin
                best = p;
                bid  = int'(m_lr[i] & 1023);
                bg   = int'((m_lr[i] >> 30) & 1);
            end
        end
        en   = rst_n && m_hcr[0] && (vgrp0_en || vgrp1_en);
        ecur = (en && best < int'(vprio_mask)) ? bid : 1023;
        fire = en && best < int'(vprio_mask) && best < int'(vrun_prio)
               && ((bg == 1) ? vgrp1_en : vgrp0_en);
        efiq = fire && bg == 0 && vfiq_en;
        eirq = fire && !efiq;
        vectors++;
        if (virq !== eirq || vfiq !== efiq || int'(vcur_pend_id) != ecur || hcr_rd !== m_hcr) begin
            miscompares++;
            $display("FAIL %s: got irq=%0b fiq=%0b cur=%0d hcr=%h expected irq=%0b fiq=%0b cur=%0d hcr=%h",
                     tag, virq, vfiq, vcur_pend_id, hcr_rd, eirq, efiq, ecur, m_hcr);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            foreach (m_lr[i]) m_lr[i] = '0;
            m_hcr = '0;
        end else begin
            if (lr_wr_en) m_lr[lr_wr_sel] = lr_wr_data;
            if (hcr_wr_en) m_hcr = hcr_wr_data;
            if (deact_miss) m_hcr[31:27] = m_hcr[31:27] + 5'd1;
        end
        #2;
        compare(tag);
        lr_wr_en = 1'b0;
        hcr_wr_en = 1'b0;
        deact_miss = 1'b0;
    endtask

    task automatic wr_lr(input int idx, input logic [31:0] d, input string tag);
        lr_wr_en = 1'b1; lr_wr_sel = IDXW'(idx); lr_wr_data = d;
        step(tag);
    endtask

    task automatic wr_hcr(input logic [31:0] d, input string tag);
        hcr_wr_en = 1'b1; hcr_wr_data = d;
        step(tag);
    endtask

    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        foreach (m_lr[i]) m_lr[i] = '0;
        m_hcr = '0;
        // R1: reset state, including a write attempted under reset
        step("R1");
        wr_lr(0, mk(5, 1, 1, 0, 0), "R1");
        step("R1");
        rst_n = 1'b1;
        step("R1");

        // R3: enabled, nothing pending
        vgrp0_en = 1; vgrp1_en = 1; vprio_mask = 8'hFF; vrun_prio = 8'hFF;
        wr_hcr(32'h1, "R3");
        // R9: write shows right after its edge; R5 id from [9:0]
        wr_lr(0, mk(5, 10, 1, 1, 0), "R9");
        // R3: tie goes to lower index
        wr_lr(1, mk(7, 10, 1, 0, 0), "R3");
        // R2: active and active+pending entries with better priority skipped
        wr_lr(2, mk(9, 2, 2, 0, 0), "R2");
        wr_lr(3, mk(11, 1, 3, 0, 0), "R2");
        wr_lr(3, mk(11, 0, 0, 0, 0), "R2");
        // R3: lower priority wins
        wr_lr(1, mk(7, 3, 1, 0, 0), "R3");
        // R7: group 0 routed to FIQ
        vfiq_en = 1; step("R7");
        // R5: mask boundary (24 not below 24), then 25
        vprio_mask = 8'd24; step("R5");
        vprio_mask = 8'd25; step("R5");
        // R6: running priority boundary
        vrun_prio = 8'd24; step("R6");
        vrun_prio = 8'd25; step("R6");
        vrun_prio = 8'hFF; vprio_mask = 8'hFF;
        // R6: winner's group disabled
        vgrp0_en = 0; step("R6");
        // R4: both group enables clear
        vgrp1_en = 0; step("R4");
        vgrp0_en = 1; vgrp1_en = 1; step("R4");
        // R4: interface enable clear
        wr_hcr(32'h0, "R4");
        wr_hcr(32'h1, "R9");
        // R10: hardware flag and reserved bits ignored
        wr_lr(2, mk(12, 0, 1, 1, 1) | 32'h0040_0C00, "R10");
        vfiq_en = 0; step("R7");
        // R3: none pending again
        for (int i = 0; i < N_LR; i++) wr_lr(i, mk(i, 0, 2, 0, 0), "R3");
        // R8: counter wraps after 32 pulses
        for (int i = 0; i < 33; i++) begin
            deact_miss = 1'b1; step("R8");
        end
        // R8: pulse in the same cycle as a control write
        hcr_wr_en = 1'b1; hcr_wr_data = 32'hF800_0001; deact_miss = 1'b1; step("R8");
        deact_miss = 1'b1; step("R8");

        // R3 random stream
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(0, 1) == 1) begin
                lr_wr_en = 1'b1;
                lr_wr_sel = IDXW'($urandom_range(0, N_LR - 1));
                lr_wr_data = $urandom();
                if ($urandom_range(0, 1) == 1) lr_wr_data[29:28] = 2'b01;
                if ($urandom_range(0, 2) == 0) lr_wr_data[27:23] = 5'd4;
            end
            if ($urandom_range(0, 15) == 0) begin
                hcr_wr_en = 1'b1;
                hcr_wr_data = $urandom();
                hcr_wr_data[0] = ($urandom_range(0, 3) != 0);
            end
            deact_miss = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) begin
                vgrp0_en = 1'($urandom_range(0, 3) != 0);
                vgrp1_en = 1'($urandom_range(0, 3) != 0);
                vfiq_en  = 1'($urandom_range(0, 1));
                vprio_mask = 8'($urandom_range(0, 255));
                vrun_prio  = 8'($urandom_range(0, 255));
            end
            step("R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule